// File: doc/BRIEF.md
# Six-Stage Instruction Pipeline Sequencer

This block is the timing control of an in-order instruction pipeline with six stages: fetch, decode, operand-address calculation, operand fetch, execute and write-back. It carries no operand data. Each instruction arrives as a small descriptor: a 4-bit tag, a flag that says it stores a result, and a flag that says it is a taken branch. The block moves the descriptors forward one stage per clock. It also decides which stage owns memory in each cycle, inserts bubbles when a stage loses that decision, and discards wrong-path work after a taken branch.

Three stages need memory: fetch, operand fetch and write-back. With the default setting they share a single port, and only one of them may use it in a cycle. A parameter can give them independent ports, which shows the ideal timing. An instruction that stores nothing leaves the pipeline from execute and never occupies write-back. The block reports which stages are occupied and the tag in each stage. It also reports retirements on two registered pulse ports, because a write-back retirement and an execute retirement can happen in the same cycle.

Top module: `pipe6_sequencer`

## Requirements
- R1: A storing instruction accepted at clock edge e moves forward one stage per edge when nothing stalls. It shows in the operand-fetch slot after edge e+3, and its write-back retirement pulse shows after edge e+6.
- R2: With `SHARED_PORT=0`, nine instructions issued on nine consecutive edges produce their last retirement pulse 14 edges after the first one is accepted.
- R3: With `SHARED_PORT=1`, at most one of fetch, operand fetch and write-back gets memory in a cycle, and the priority is write-back, then operand fetch, then fetch. A stage that loses holds its slot and so does every stage behind it. The stage ahead of it receives a bubble, so the losing instruction retires one edge later than it otherwise would.
- R4: An instruction whose store flag is 0 never enters write-back. Its retirement pulse shows after edge e+5 on the execute port. `retire_valid[0]` marks the write-back port and `retire_valid[1]` marks the execute port, and both may be set in the same cycle.
- R5: When the execute slot holds a taken branch, the next edge turns the fetch through execute slots into bubbles. The discarded instructions never retire, and the branch itself retires normally.
- R6: `issue_ready` is low during a flush cycle and while the fetch slot is held. An instruction is accepted on an edge where both `issue_valid` and `issue_ready` are high, so fetch restarts on the edge after a flush.
- R7: A synchronous active-high reset empties every slot, clears both retirement pulses and leaves `issue_ready` high.
- R8: Stage k, with fetch=0, decode=1, address=2, operand fetch=3, execute=4 and write-back=5, reports its occupancy on `stage_valid[k]` and its tag on `stage_id[4k+3:4k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | A descriptor is offered to fetch |
| issue_id | input | 4 | Tag of the offered instruction |
| issue_stores | input | 1 | Instruction stores a result (needs write-back) |
| issue_taken_br | input | 1 | Instruction is a branch that resolves taken |
| issue_ready | output | 1 | Fetch accepts a descriptor on the next edge |
| stage_valid | output | 6 | Occupancy per stage, bit k = stage k |
| stage_id | output | 24 | Tag per stage, 4 bits per stage |
| retire_valid | output | 2 | Retirement pulses: bit 0 write-back, bit 1 execute |
| retire_id_wo | output | 4 | Tag retiring from write-back |
| retire_id_ei | output | 4 | Tag retiring from execute |

## Verification
The bench targets the two port conflicts, operand fetch against write-back and fetch against operand fetch. In each case it checks where the bubble appears and how late the victim retires. A design with the wrong priority would instead delay the older instruction or let two stages access memory at once. A stream that mixes storing and non-storing instructions forces retirements on both ports in the same cycle, so a design that routed every instruction through write-back would be off by one edge and would lose pulses. A taken branch with four younger instructions behind it checks that none of them retires, that fetch stays closed for exactly one cycle, and that a design which flushed one stage too few would be caught because a wrong-path tag would still be retired.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  parameter int unsigned ID_W = 4;
  localparam int unsigned N_ST  = 6;
  localparam int unsigned ST_FI = 0;
  localparam int unsigned ST_DI = 1;
  localparam int unsigned ST_CO = 2;
  localparam int unsigned ST_FO = 3;
  localparam int unsigned ST_EI = 4;
  localparam int unsigned ST_WO = 5;

  typedef struct packed {
    logic            vld;
    logic            stores;
    logic            jumps;
    logic [ID_W-1:0] tag;
  } slot_t;

  localparam slot_t BUBBLE = '0;
endpackage

// File: rtl/pseq_port_arb.sv
module pseq_port_arb #(
  parameter bit SHARED = 1'b1
) (
  input  logic fi_req,
  input  logic fo_req,
  input  logic wo_req,
  output logic fi_gnt,
  output logic fo_gnt,
  output logic wo_gnt
);
  generate
    if (SHARED) begin : g_shared
      // single port: write-back over operand fetch over fetch
      assign wo_gnt = wo_req;
      assign fo_gnt = fo_req & ~wo_req;
      assign fi_gnt = fi_req & ~wo_req & ~fo_req;
    end else begin : g_split
      assign wo_gnt = wo_req;
      assign fo_gnt = fo_req;
      assign fi_gnt = fi_req;
    end
  endgenerate
endmodule

// File: rtl/pseq_stage.sv
module pseq_stage
  import pseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  flush,
  input  logic  hold_self,
  input  logic  hold_prev,
  input  slot_t up,
  output slot_t q
);
  always_ff @(posedge clk) begin
    if (rst)             q <= BUBBLE;
    else if (flush)      q <= BUBBLE;
    else if (!hold_self) q <= hold_prev ? BUBBLE : up;
  end
endmodule

// File: rtl/pseq_retire.sv
module pseq_retire
  import pseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ei_vld,
  input  logic            ei_stores,
  input  logic [ID_W-1:0] ei_tag,
  input  logic            wo_vld,
  input  logic [ID_W-1:0] wo_tag,
  output logic [1:0]      rvld,
  output logic [ID_W-1:0] rid_wo,
  output logic [ID_W-1:0] rid_ei
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvld   <= '0;
      rid_wo <= '0;
      rid_ei <= '0;
    end else begin
      rvld   <= {ei_vld & ~ei_stores, wo_vld};
      rid_wo <= wo_tag;
      rid_ei <= ei_tag;
    end
  end
endmodule

// File: rtl/pipe6_sequencer.sv
module pipe6_sequencer
  import pseq_pkg::*;
#(
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  input  logic [ID_W-1:0]      issue_id,
  input  logic                 issue_stores,
  input  logic                 issue_taken_br,
  output logic                 issue_ready,
  output logic [N_ST-1:0]      stage_valid,
  output logic [N_ST*ID_W-1:0] stage_id,
  output logic [1:0]           retire_valid,
  output logic [ID_W-1:0]      retire_id_wo,
  output logic [ID_W-1:0]      retire_id_ei
);
  slot_t           st [N_ST];
  slot_t           up [N_ST];
  logic [N_ST-1:0] blk, hold, hprev;
  logic            g_fi, g_fo, g_wo, flush;
  logic            ei_stores, ei_jumps, wo_stores;

  assign ei_stores = st[ST_EI].stores;
  assign ei_jumps  = st[ST_EI].jumps;
  assign wo_stores = st[ST_WO].stores;
  assign flush     = st[ST_EI].vld & ei_jumps;

  pseq_port_arb #(.SHARED(SHARED_PORT)) u_arb (
    .fi_req(st[ST_FI].vld), .fo_req(st[ST_FO].vld), .wo_req(st[ST_WO].vld),
    .fi_gnt(g_fi), .fo_gnt(g_fo), .wo_gnt(g_wo)
  );

  // a stage that loses the port stalls, and so does everything behind it
  always_comb begin
    blk        = '0;
    blk[ST_FI] = st[ST_FI].vld & ~g_fi;
    blk[ST_FO] = st[ST_FO].vld & ~g_fo;
    blk[ST_WO] = st[ST_WO].vld & ~g_wo;
    hold[N_ST-1] = blk[N_ST-1];
    for (int k = N_ST-2; k >= 0; k--) hold[k] = hold[k+1] | blk[k];
  end

  assign issue_ready = ~flush & ~hold[ST_FI];

  always_comb begin
    up[ST_FI]        = BUBBLE;
    up[ST_FI].vld    = issue_valid;
    up[ST_FI].stores = issue_stores;
    up[ST_FI].jumps  = issue_taken_br;
    up[ST_FI].tag    = issue_id;
    for (int k = 1; k < N_ST; k++) up[k] = st[k-1];
    // non-storing instructions leave from execute
    up[ST_WO].vld = st[ST_EI].vld & st[ST_EI].stores;
  end

  genvar k;
  generate
    for (k = 0; k < N_ST; k++) begin : g_st
      if (k == 0) begin : g_head
        assign hprev[k] = 1'b0;
      end else begin : g_body
        assign hprev[k] = hold[k-1];
      end
      pseq_stage u_stage (
        .clk(clk), .rst(rst),
        .flush(flush && (k < ST_WO)),
        .hold_self(hold[k]), .hold_prev(hprev[k]),
        .up(up[k]), .q(st[k])
      );
      assign stage_valid[k]             = st[k].vld;
      assign stage_id[k*ID_W +: ID_W]   = st[k].tag;
    end
  endgenerate

  pseq_retire u_ret (
    .clk(clk), .rst(rst),
    .ei_vld(st[ST_EI].vld), .ei_stores(ei_stores), .ei_tag(st[ST_EI].tag),
    .wo_vld(st[ST_WO].vld), .wo_tag(st[ST_WO].tag),
    .rvld(retire_valid), .rid_wo(retire_id_wo), .rid_ei(retire_id_ei)
  );
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker
  import pseq_pkg::*;
#(
  parameter bit SHARED = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 issue_ready,
  input logic [N_ST-1:0]      stage_valid,
  input logic [N_ST*ID_W-1:0] stage_id,
  input logic [1:0]           retire_valid,
  input logic [ID_W-1:0]      retire_id_wo,
  input logic [ID_W-1:0]      retire_id_ei,
  input logic [2:0]           gnt,
  input logic                 ei_stores,
  input logic                 ei_jumps,
  input logic                 wo_stores
);
  logic flush_c;
  assign flush_c = stage_valid[ST_EI] & ei_jumps;

  generate
    if (SHARED) begin : g_one
      p_one_port_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    end
  endgenerate

  p_wo_first_r3: assert property (@(posedge clk) disable iff (rst)
    stage_valid[ST_WO] |-> gnt[2]);

  p_fi_gnt_occ_r3: assert property (@(posedge clk) disable iff (rst)
    gnt[0] |-> stage_valid[ST_FI]);

  p_fo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (stage_valid[ST_FO] && !gnt[1] && !flush_c) |=>
      (stage_valid[ST_FO] && $stable(stage_id[ST_FO*ID_W +: ID_W])));

  p_ei_to_wo_r1: assert property (@(posedge clk) disable iff (rst)
    (stage_valid[ST_EI] && ei_stores) |=>
      (stage_valid[ST_WO] && stage_id[ST_WO*ID_W +: ID_W] == $past(stage_id[ST_EI*ID_W +: ID_W])));

  p_wo_retire_r1: assert property (@(posedge clk) disable iff (rst)
    stage_valid[ST_WO] |=> (retire_valid[0] && retire_id_wo == $past(stage_id[ST_WO*ID_W +: ID_W])));

  p_wo_stores_only_r4: assert property (@(posedge clk) disable iff (rst)
    stage_valid[ST_WO] |-> wo_stores);

  p_ei_retire_r4: assert property (@(posedge clk) disable iff (rst)
    (stage_valid[ST_EI] && !ei_stores) |=>
      (retire_valid[1] && retire_id_ei == $past(stage_id[ST_EI*ID_W +: ID_W])));

  p_flush_clear_r5: assert property (@(posedge clk) disable iff (rst)
    flush_c |=> (stage_valid[ST_EI:ST_FI] == '0));

  p_flush_closed_r6: assert property (@(posedge clk) disable iff (rst)
    flush_c |-> !issue_ready);

  p_reset_empty_r7: assert property (@(posedge clk)
    rst |=> (stage_valid == '0 && retire_valid == '0));
endmodule

bind pipe6_sequencer pseq_checker #(.SHARED(SHARED_PORT)) u_chk (
  .clk(clk), .rst(rst), .issue_ready(issue_ready),
  .stage_valid(stage_valid), .stage_id(stage_id),
  .retire_valid(retire_valid), .retire_id_wo(retire_id_wo), .retire_id_ei(retire_id_ei),
  .gnt({g_wo, g_fo, g_fi}),
  .ei_stores(ei_stores), .ei_jumps(ei_jumps), .wo_stores(wo_stores)
);

// File: tb/test_pipe6_sequencer.sv
`timescale 1ns/1ps
module test_pipe6_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic va = 1'b0, vb = 1'b0;
  logic [3:0] iid = '0;
  logic ist = 1'b0, ibr = 1'b0;

  logic rdy_a, rdy_b;
  logic [5:0] sv_a, sv_b;
  logic [23:0] sid_a, sid_b;
  logic [1:0] rv_a, rv_b;
  logic [3:0] rw_a, re_a, rw_b, re_b;

  int nchk = 0, nerr = 0, c = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe6_sequencer #(.SHARED_PORT(1'b1)) i_pipe6_sequencer (
    .clk(clk), .rst(rst), .issue_valid(va), .issue_id(iid), .issue_stores(ist),
    .issue_taken_br(ibr), .issue_ready(rdy_a), .stage_valid(sv_a), .stage_id(sid_a),
    .retire_valid(rv_a), .retire_id_wo(rw_a), .retire_id_ei(re_a));

  pipe6_sequencer #(.SHARED_PORT(1'b0)) i_ideal (
    .clk(clk), .rst(rst), .issue_valid(vb), .issue_id(iid), .issue_stores(ist),
    .issue_taken_br(ibr), .issue_ready(rdy_b), .stage_valid(sv_b), .stage_id(sid_b),
    .retire_valid(rv_b), .retire_id_wo(rw_b), .retire_id_ei(re_b));

  // {stores, id}: nine back-to-back instructions for the ideal-port stream
  localparam logic [4:0] VEC [0:8] = '{5'h11, 5'h02, 5'h13, 5'h14, 5'h05,
                                       5'h06, 5'h17, 5'h08, 5'h19};

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s at step %0d: actual %0h expected %0h", req, c, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    c++;
  endtask

  task automatic run_to(input int n);
    while (c < n) step();
  endtask

  task automatic drive(input logic a, input logic b, input logic [3:0] id,
                       input logic s, input logic br);
    va = a; vb = b; iid = id; ist = s; ibr = br;
  endtask

  function automatic logic [3:0] tag_at(input logic [23:0] v, input int k);
    return v[k*4 +: 4];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int last;
    logic [1:0] ev;
    logic [3:0] ewo, eei;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 valid", sv_a, 0);
    check("R7 retire", rv_a, 0);
    check("R7 ready", rdy_a, 1);
    rst = 1'b0;
    step();

    // R1: single storing instruction on the shared-port block
    c = -1; drive(1, 0, 4'hA, 1, 0);
    run_to(0); drive(0, 0, 0, 0, 0);
    run_to(3);
    check("R1 FO slot", sv_a, 6'b001000);
    check("R8 FO tag", tag_at(sid_a, 3), 4'hA);
    run_to(5); check("R1 no early retire", rv_a, 0);
    run_to(6); check("R1 retire wo", rv_a, 2'b01); check("R1 retire tag", rw_a, 4'hA);
    run_to(7); check("R1 pulse ends", rv_a, 0);
    run_to(9);

    // R4: non-storing instruction leaves from execute
    c = -1; drive(1, 0, 4'hB, 0, 0);
    run_to(0); drive(0, 0, 0, 0, 0);
    run_to(4); check("R4 EI slot", sv_a, 6'b010000);
    run_to(5);
    check("R4 retire ei", rv_a, 2'b10); check("R4 ei tag", re_a, 4'hB);
    check("R4 WO unused", sv_a, 0);
    run_to(8);

    // R3: operand fetch loses to write-back
    c = -1; drive(1, 0, 4'h1, 1, 0);
    run_to(0); drive(0, 0, 0, 0, 0);
    run_to(1); drive(1, 0, 4'h2, 1, 0);
    run_to(2); drive(0, 0, 0, 0, 0);
    run_to(5); check("R3 FO+WO", sv_a, 6'b101000);
    run_to(6);
    check("R3 FO held, bubble ahead", sv_a, 6'b001000);
    check("R3 held tag", tag_at(sid_a, 3), 4'h2);
    check("R3 older retires", rw_a, 4'h1);
    run_to(8); check("R3 no retire at 8", rv_a, 0);
    run_to(9); check("R3 late retire", rv_a, 2'b01); check("R3 late tag", rw_a, 4'h2);
    run_to(11);

    // R3/R6: fetch loses to operand fetch
    c = -1; drive(1, 0, 4'h3, 1, 0);
    run_to(0); drive(0, 0, 0, 0, 0);
    run_to(2); drive(1, 0, 4'h4, 1, 0);
    run_to(3); drive(0, 0, 0, 0, 0);
    check("R3 FI+FO", sv_a, 6'b001001);
    check("R6 ready low on hold", rdy_a, 0);
    run_to(4);
    check("R3 FI held", sv_a, 6'b010001);
    check("R3 FI tag", tag_at(sid_a, 0), 4'h4);
    run_to(6); check("R3 first retire", rw_a, 4'h3);
    run_to(9); check("R3 fetch victim not yet", rv_a, 0);
    run_to(10); check("R3 fetch victim retire", rv_a, 2'b01); check("R3 victim tag", rw_a, 4'h4);
    run_to(12);

    // R7: reset in mid-flight
    drive(1, 0, 4'h7, 1, 0); step(); step(); drive(0, 0, 0, 0, 0);
    rst = 1'b1; step(); rst = 1'b0;
    check("R7 mid reset valid", sv_a, 0);
    check("R7 mid reset ready", rdy_a, 1);
    step(); step();

    // R2/R4: nine-instruction stream on the split-port block
    last = -1;
    c = -1; drive(0, 1, VEC[0][3:0], VEC[0][4], 0);
    for (int s = 0; s <= 16; s++) begin
      step();
      ev = 0; ewo = 0; eei = 0;
      for (int i = 0; i < 9; i++) begin
        if (VEC[i][4] && i + 6 == c) begin ev[0] = 1; ewo = VEC[i][3:0]; end
        if (!VEC[i][4] && i + 5 == c) begin ev[1] = 1; eei = VEC[i][3:0]; end
      end
      check("R4 stream pulses", rv_b, ev);
      if (ev[0]) check("R2 wo tag", rw_b, ewo);
      if (ev[1]) check("R4 ei tag", re_b, eei);
      if (rv_b != 0) last = c;
      if (c + 1 < 9) begin
        check("R2 ready", rdy_b, 1);
        drive(0, 1, VEC[c+1][3:0], VEC[c+1][4], 0);
      end else drive(0, 0, 0, 0, 0);
    end
    check("R2 fourteen edges", last, 14);

    // R5/R6: taken branch flushes four younger instructions
    c = -1; drive(0, 1, 4'h1, 0, 1);
    for (int s = 0; s < 4; s++) begin
      step();
      drive(0, 1, 4'(c + 2), 1, 0);
    end
    run_to(4); drive(0, 1, 4'h6, 1, 0);
    check("R5 full pipe", sv_b, 6'b011111);
    check("R6 ready low on flush", rdy_b, 0);
    run_to(5);
    check("R5 flushed", sv_b, 0);
    check("R5 branch retires", rv_b, 2'b10); check("R5 branch tag", re_b, 4'h1);
    check("R6 ready back", rdy_b, 1);
    run_to(6); drive(0, 0, 0, 0, 0);
    check("R6 refetch", sv_b, 6'b000001); check("R6 refetch tag", tag_at(sid_b, 0), 4'h6);
    for (int s = 7; s <= 12; s++) begin
      run_to(s);
      check("R5 only target retires", rv_b, (c == 12) ? 2'b01 : 2'b00);
    end
    check("R5 target tag", rw_b, 4'h6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule